// File: doc/BRIEF.md
# Peripheral Bus Clock Mask Controller

This block lets software switch the bus clock of each on-chip peripheral on or off. It keeps two mask words, one for peripherals on the high-speed system bus and one for peripherals behind the peripheral bus bridge. Each bit drives a latch-based clock gate, so a peripheral receives only whole clock pulses. Software reads and writes the two words through a zero-wait-state APB-style slave port. The word for the system bus sits at offset 0x00 and the word for the peripheral bus sits at offset 0x04.

The block also sits between the peripheral bridge and the peripherals as an access guard. When the bridge selects a peripheral whose peripheral-bus clock is masked, the select is not passed on. The bridge then gets a zero read value and an error response. Two mask bits are special. One is the controller's own peripheral-bus clock and the other is the system-bus clock of the bridge that serves it. Clearing either bit freezes both mask words until the next reset. A parameter marks one peripheral-bus peripheral as missing from the package. Its bit then starts at 0 and can never be set.

Top module: `clk_mask_ctrl`

## Requirements
- R1: After reset, every implemented mask bit is 1. With the default sizes, offset 0x00 reads 0x000000FF and offset 0x04 reads 0x00FFFFFF, and every gated clock output pulses on each clock cycle.
- R2: A register write takes effect on the clock edge that ends the access phase. Bit value 1 in a mask word turns the matching peripheral clock on, and 0 turns it off.
- R3: Bits above the implemented count read as 0 and ignore writes. An address other than 0x00 or 0x04 reads as 0 and its writes change nothing.
- R4: When HAS_OPT is 0, peripheral-bus bit OPT_IDX (18 by default) reads 0 after reset, stays 0 after a write of 1, and its gated clock never pulses.
- R5: The two mask words are independent. A write to one word leaves the other word unchanged.
- R6: In any bridge cycle where brg_psel selects a peripheral whose peripheral-bus mask bit is 0, prph_psel stays 0 for that peripheral. In the access phase the bridge sees brg_prdata 0, brg_pslverr 1 and brg_pready 1.
- R7: For a peripheral whose bit is 1, brg_psel passes to prph_psel, and prph_prdata, prph_pready and prph_pslverr pass back to the bridge unchanged.
- R8: Writing a cleared peripheral-bus bit back to 1 makes the next bridge access to that peripheral pass through normally.
- R9: Once peripheral-bus bit SELF_IDX (1 by default) or system-bus bit BRIDGE_IDX (0 by default) is 0, later writes to either mask word are ignored.
- R10: Holding rst_n low through a rising clock edge restores every mask bit to its default and removes the write freeze of R9.
- R11: A gated clock output is low for the whole low phase of clk. A mask change takes effect from the first whole high phase after the write edge, so no shortened pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock and source for all gated clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_psel | input | 1 | Register port select |
| reg_penable | input | 1 | Register port access phase |
| reg_pwrite | input | 1 | Register port write (1) or read (0) |
| reg_paddr | input | ADDR_W | Register byte address |
| reg_pwdata | input | 32 | Register write data |
| reg_prdata | output | 32 | Register read data |
| brg_psel | input | N_APB | One-hot peripheral select from the bridge |
| brg_penable | input | 1 | Bridge access phase |
| brg_prdata | output | 32 | Read data returned to the bridge |
| brg_pready | output | 1 | Ready returned to the bridge |
| brg_pslverr | output | 1 | Error returned to the bridge |
| prph_psel | output | N_APB | Peripheral selects after masking |
| prph_penable | output | 1 | Access phase forwarded to the peripherals |
| prph_prdata | input | 32 | Read data from the selected peripheral |
| prph_pready | input | 1 | Ready from the selected peripheral |
| prph_pslverr | input | 1 | Error from the selected peripheral |
| ahb_en | output | N_AHB | Current system-bus mask bits |
| apb_en | output | N_APB | Current peripheral-bus mask bits |
| ahb_gclk | output | N_AHB | Gated system-bus clocks |
| apb_gclk | output | N_APB | Gated peripheral-bus clocks |

## Verification
A wrong mask bit shows at the ports in three places. It appears on ahb_en or apb_en right after the write edge. It appears on the gated clock pulse count within one cycle. It also changes whether the next bridge access is passed through or answered with an error. A false freeze, or a missing one, shows on the next read-back of a mask word after a write. A faulty clock latch shows as a gated output that is high during the low phase, or as a pulse count that is off by one in the cycle after a mask change. A fault on the missing-peripheral parameter shows on the first read of the peripheral-bus word after reset.

// File: rtl/clkmask_pkg.sv
// Package: shared constants, decode type and mask helper functions for the
// peripheral clock mask controller. Assumes mask words of at most 32 bits.
package clkmask_pkg;

    localparam int unsigned WORD_W = 32;

    // Register target decoded from the byte address.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_AHB  = 2'd1,
        TGT_APB  = 2'd2
    } tgt_e;

    // Word with the lowest n bits set.
    function automatic logic [WORD_W-1:0] low_ones(input int unsigned n);
        logic [WORD_W-1:0] r;
        r = '0;
        for (int unsigned i = 0; i < WORD_W; i++) begin
            if (i < n) r[i] = 1'b1;
        end
        return r;
    endfunction

    // Peripheral-bus bits that may ever be 1: the implemented bits, without
    // the optional peripheral when the package lacks it.
    function automatic logic [WORD_W-1:0] apb_allowed(input int unsigned n,
                                                      input bit has_opt,
                                                      input int unsigned opt_idx);
        logic [WORD_W-1:0] r;
        r = low_ones(n);
        if (!has_opt) r = r & ~(WORD_W'(1) << opt_idx);
        return r;
    endfunction

endpackage

// File: rtl/clk_gate_cell.sv
// Module: clk_gate_cell
// Latch-based clock gate. The enable is captured while clk_i is low and held
// while it is high, so gclk_o carries only whole high phases of clk_i.
// Assumes en_i is driven by logic clocked on the rising edge of clk_i.
module clk_gate_cell (
    input  logic clk_i,
    input  logic rst_n,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Transparent during the low phase, closed during the high phase.
    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    // Output pulse: source clock qualified by the held enable.
    assign gclk_o = clk_i & en_lat;

    // Held enable seen at each rising edge, for the stability check.
    logic en_at_rise;
    always_ff @(posedge clk_i) begin
        en_at_rise <= en_lat;
    end

    // R11: the enable must not move during a high phase (no short pulse).
    assert_gate_hold_R11: assert property (@(negedge clk_i) disable iff (!rst_n)
        en_lat == en_at_rise)
        else $error("gate enable changed while clock high");

endmodule

// File: rtl/clk_mask_regs.sv
// Module: clk_mask_regs
// Holds the system-bus and peripheral-bus mask words behind a zero-wait APB
// style slave. Writes land at the end of the access phase. Writes are frozen
// while the controller's own bit or its bridge's bit is clear. Assumes a
// single master and word-aligned offsets.
module clk_mask_regs
    import clkmask_pkg::*;
#(
    parameter int unsigned          N_AHB      = 8,
    parameter int unsigned          N_APB      = 24,
    parameter int unsigned          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]    AHB_OFS    = 'h00,
    parameter logic [ADDR_W-1:0]    APB_OFS    = 'h04,
    parameter int unsigned          SELF_IDX   = 1,
    parameter int unsigned          BRIDGE_IDX = 0,
    parameter bit                   HAS_OPT    = 1'b1,
    parameter int unsigned          OPT_IDX    = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [WORD_W-1:0]  pwdata,
    output logic [WORD_W-1:0]  prdata,
    output logic [N_AHB-1:0]   ahb_mask_o,
    output logic [N_APB-1:0]   apb_mask_o
);

    localparam logic [WORD_W-1:0] AHB_ALLOW = low_ones(N_AHB);
    localparam logic [WORD_W-1:0] APB_ALLOW = apb_allowed(N_APB, HAS_OPT, OPT_IDX);

    logic [WORD_W-1:0] ahb_q;
    logic [WORD_W-1:0] apb_q;
    tgt_e              tgt;
    logic              wr_fire;
    logic              locked;

    // Address decode to a mask word.
    always_comb begin
        tgt = TGT_NONE;
        if (paddr == AHB_OFS)      tgt = TGT_AHB;
        else if (paddr == APB_OFS) tgt = TGT_APB;
    end

    // Write strobe in the access phase.
    assign wr_fire = psel & penable & pwrite;

    // Freeze when the controller or its bridge has lost its clock.
    assign locked = ~apb_q[SELF_IDX] | ~ahb_q[BRIDGE_IDX];

    // Mask word storage with defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ahb_q <= AHB_ALLOW;
            apb_q <= APB_ALLOW;
        end else if (wr_fire && !locked) begin
            case (tgt)
                TGT_AHB: ahb_q <= pwdata & AHB_ALLOW;
                TGT_APB: apb_q <= pwdata & APB_ALLOW;
                default: ;
            endcase
        end
    end

    // Read data mux; unmapped offsets read zero.
    always_comb begin
        case (tgt)
            TGT_AHB: prdata = ahb_q;
            TGT_APB: prdata = apb_q;
            default: prdata = '0;
        endcase
    end

    assign ahb_mask_o = ahb_q[N_AHB-1:0];
    assign apb_mask_o = apb_q[N_APB-1:0];

    // R2: an accepted write to the system-bus word lands on the next edge.
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !locked && tgt == TGT_AHB) |=> (ahb_q == ($past(pwdata) & AHB_ALLOW)))
        else $error("mask write did not land");

    // R9: while frozen, neither mask word moves.
    assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(ahb_q) && $stable(apb_q)))
        else $error("mask word changed while frozen");

    // R4: the missing peripheral's bit stays clear.
    if (!HAS_OPT) begin : g_opt_absent
        assert_absent_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            apb_q[OPT_IDX] == 1'b0)
            else $error("absent peripheral bit set");
    end

endmodule

// File: rtl/clk_access_guard.sv
// Module: clk_access_guard
// Sits between the peripheral bridge and the peripherals. It drops selects
// to peripherals whose clock is masked and answers such accesses itself with
// zero data and an error. Assumes one-hot selects and a single read mux.
module clk_access_guard #(
    parameter int unsigned N_APB  = 24,
    parameter int unsigned DATA_W = 32
) (
    input  logic [N_APB-1:0]  mask_i,
    input  logic [N_APB-1:0]  up_psel,
    input  logic              up_penable,
    output logic [DATA_W-1:0] up_prdata,
    output logic              up_pready,
    output logic              up_pslverr,
    output logic [N_APB-1:0]  dn_psel,
    output logic              dn_penable,
    input  logic [DATA_W-1:0] dn_prdata,
    input  logic              dn_pready,
    input  logic              dn_pslverr
);

    logic hit_masked;

    // Selects reach only clocked peripherals.
    assign dn_psel    = up_psel & mask_i;
    assign dn_penable = up_penable;

    // A select to any masked peripheral is answered locally.
    assign hit_masked = |(up_psel & ~mask_i);

    // Response mux: local error reply or the peripheral's reply.
    always_comb begin
        if (hit_masked) begin
            up_prdata  = '0;
            up_pready  = 1'b1;
            up_pslverr = up_penable;
        end else begin
            up_prdata  = dn_prdata;
            up_pready  = dn_pready;
            up_pslverr = dn_pslverr;
        end
    end

endmodule

// File: rtl/clk_mask_ctrl.sv
// Module: clk_mask_ctrl (top)
// Peripheral bus clock mask controller: mask registers, one clock gate per
// peripheral clock, and the bridge access guard. Assumes all gated clocks
// come from the one source clock clk.
module clk_mask_ctrl
    import clkmask_pkg::*;
#(
    parameter int unsigned          N_AHB      = 8,
    parameter int unsigned          N_APB      = 24,
    parameter int unsigned          ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]    AHB_OFS    = 'h00,
    parameter logic [ADDR_W-1:0]    APB_OFS    = 'h04,
    parameter int unsigned          SELF_IDX   = 1,
    parameter int unsigned          BRIDGE_IDX = 0,
    parameter bit                   HAS_OPT    = 1'b1,
    parameter int unsigned          OPT_IDX    = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_psel,
    input  logic               reg_penable,
    input  logic               reg_pwrite,
    input  logic [ADDR_W-1:0]  reg_paddr,
    input  logic [WORD_W-1:0]  reg_pwdata,
    output logic [WORD_W-1:0]  reg_prdata,
    input  logic [N_APB-1:0]   brg_psel,
    input  logic               brg_penable,
    output logic [WORD_W-1:0]  brg_prdata,
    output logic               brg_pready,
    output logic               brg_pslverr,
    output logic [N_APB-1:0]   prph_psel,
    output logic               prph_penable,
    input  logic [WORD_W-1:0]  prph_prdata,
    input  logic               prph_pready,
    input  logic               prph_pslverr,
    output logic [N_AHB-1:0]   ahb_en,
    output logic [N_APB-1:0]   apb_en,
    output logic [N_AHB-1:0]   ahb_gclk,
    output logic [N_APB-1:0]   apb_gclk
);

    logic [N_AHB-1:0] ahb_mask;
    logic [N_APB-1:0] apb_mask;

    clk_mask_regs #(
        .N_AHB(N_AHB), .N_APB(N_APB), .ADDR_W(ADDR_W),
        .AHB_OFS(AHB_OFS), .APB_OFS(APB_OFS),
        .SELF_IDX(SELF_IDX), .BRIDGE_IDX(BRIDGE_IDX),
        .HAS_OPT(HAS_OPT), .OPT_IDX(OPT_IDX)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .psel(reg_psel), .penable(reg_penable), .pwrite(reg_pwrite),
        .paddr(reg_paddr), .pwdata(reg_pwdata), .prdata(reg_prdata),
        .ahb_mask_o(ahb_mask), .apb_mask_o(apb_mask)
    );

    clk_access_guard #(.N_APB(N_APB), .DATA_W(WORD_W)) u_guard (
        .mask_i(apb_mask),
        .up_psel(brg_psel), .up_penable(brg_penable),
        .up_prdata(brg_prdata), .up_pready(brg_pready), .up_pslverr(brg_pslverr),
        .dn_psel(prph_psel), .dn_penable(prph_penable),
        .dn_prdata(prph_prdata), .dn_pready(prph_pready), .dn_pslverr(prph_pslverr)
    );

    assign ahb_en = ahb_mask;
    assign apb_en = apb_mask;

    // One gate per system-bus peripheral clock.
    for (genvar i = 0; i < N_AHB; i++) begin : g_ahb_gate
        clk_gate_cell u_gate (.clk_i(clk), .rst_n(rst_n), .en_i(ahb_mask[i]), .gclk_o(ahb_gclk[i]));
    end

    // One gate per peripheral-bus peripheral clock.
    for (genvar i = 0; i < N_APB; i++) begin : g_apb_gate
        clk_gate_cell u_gate (.clk_i(clk), .rst_n(rst_n), .en_i(apb_mask[i]), .gclk_o(apb_gclk[i]));
    end

    // R6: a masked peripheral never sees its select.
    assert_blocked_no_sel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (prph_psel & ~apb_en) == '0)
        else $error("select reached masked peripheral");

    // R6: an access phase to a masked peripheral gets zero data and an error.
    assert_blocked_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_penable && ((brg_psel & ~apb_en) != '0)) |->
        (brg_pslverr && brg_pready && brg_prdata == '0))
        else $error("masked access not answered with error");

endmodule

// File: tb/clk_mask_ctrl_tb.sv
module clk_mask_ctrl_tb;

    localparam int CLK_P = 10;
    localparam int NA    = 8;
    localparam int NP    = 24;
    localparam int NV    = 16;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic            rst_n = 1'b0;
    logic            reg_psel = 0, reg_psel_b = 0, reg_penable = 0, reg_pwrite = 0;
    logic [7:0]      reg_paddr = '0;
    logic [31:0]     reg_pwdata = '0;
    logic [31:0]     prdata_a, prdata_b;
    logic [NP-1:0]   brg_psel = '0;
    logic            brg_penable = 0;
    logic [31:0]     brg_prdata, brg_prdata_b;
    logic            brg_pready, brg_pslverr, brg_pready_b, brg_pslverr_b;
    logic [NP-1:0]   prph_psel, prph_psel_b;
    logic            prph_penable, prph_penable_b;
    logic [31:0]     prph_prdata = '0;
    logic            prph_pready = 1, prph_pslverr = 0;
    logic [NA-1:0]   ahb_en_a, ahb_en_b, ahb_gclk_a, ahb_gclk_b;
    logic [NP-1:0]   apb_en_a, apb_en_b, apb_gclk_a, apb_gclk_b;

    clk_mask_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_psel(reg_psel), .reg_penable(reg_penable), .reg_pwrite(reg_pwrite),
        .reg_paddr(reg_paddr), .reg_pwdata(reg_pwdata), .reg_prdata(prdata_a),
        .brg_psel(brg_psel), .brg_penable(brg_penable), .brg_prdata(brg_prdata),
        .brg_pready(brg_pready), .brg_pslverr(brg_pslverr),
        .prph_psel(prph_psel), .prph_penable(prph_penable), .prph_prdata(prph_prdata),
        .prph_pready(prph_pready), .prph_pslverr(prph_pslverr),
        .ahb_en(ahb_en_a), .apb_en(apb_en_a), .ahb_gclk(ahb_gclk_a), .apb_gclk(apb_gclk_a)
    );

    // Package variant without the optional peripheral (R4).
    clk_mask_ctrl #(.HAS_OPT(1'b0)) u_dut_nopt (
        .clk(clk), .rst_n(rst_n),
        .reg_psel(reg_psel_b), .reg_penable(reg_penable), .reg_pwrite(reg_pwrite),
        .reg_paddr(reg_paddr), .reg_pwdata(reg_pwdata), .reg_prdata(prdata_b),
        .brg_psel(brg_psel), .brg_penable(brg_penable), .brg_prdata(brg_prdata_b),
        .brg_pready(brg_pready_b), .brg_pslverr(brg_pslverr_b),
        .prph_psel(prph_psel_b), .prph_penable(prph_penable_b), .prph_prdata(prph_prdata),
        .prph_pready(prph_pready), .prph_pslverr(prph_pslverr),
        .ahb_en(ahb_en_b), .apb_en(apb_en_b), .ahb_gclk(ahb_gclk_b), .apb_gclk(apb_gclk_b)
    );

    int n_chk = 0;
    int n_bad = 0;
    int pc_a3 = 0, pc_b17 = 0, pc_b18 = 0;

    always @(posedge apb_gclk_a[3])  pc_a3++;
    always @(posedge apb_gclk_b[17]) pc_b17++;
    always @(posedge apb_gclk_b[18]) pc_b18++;

    // Vector: {req[7:0], wr, addr[7:0], data[31:0], expected read[31:0]}
    localparam logic [80:0] VEC [NV] = '{
        {8'd1, 1'b0, 8'h00, 32'h0,        32'h0000_00FF},  // R1 system-bus default
        {8'd1, 1'b0, 8'h04, 32'h0,        32'h00FF_FFFF},  // R1 peripheral-bus default
        {8'd3, 1'b0, 8'h08, 32'h0,        32'h0},          // R3 unmapped reads zero
        {8'd2, 1'b1, 8'h00, 32'hFFFF_FF5B, 32'h0},
        {8'd3, 1'b0, 8'h00, 32'h0,        32'h0000_005B},  // R2/R3 upper bits dropped
        {8'd5, 1'b0, 8'h04, 32'h0,        32'h00FF_FFFF},  // R5 other word untouched
        {8'd2, 1'b1, 8'h04, 32'hA5F0_F00E, 32'h0},
        {8'd2, 1'b0, 8'h04, 32'h0,        32'h00F0_F00E},  // R2
        {8'd5, 1'b0, 8'h00, 32'h0,        32'h0000_005B},  // R5
        {8'd3, 1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0},
        {8'd3, 1'b0, 8'h0C, 32'h0,        32'h0},          // R3
        {8'd3, 1'b0, 8'h00, 32'h0,        32'h0000_005B},  // R3 unmapped write no effect
        {8'd2, 1'b1, 8'h00, 32'h0000_00FF, 32'h0},
        {8'd2, 1'b0, 8'h00, 32'h0,        32'h0000_00FF},  // R2
        {8'd2, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0},
        {8'd2, 1'b0, 8'h04, 32'h0,        32'h00FF_FFFF}   // R2
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Two-phase register transfer; read data sampled in the access phase.
    task automatic reg_xfer(input bit to_b, input bit wr, input logic [7:0] a,
                            input logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        reg_psel   = !to_b;
        reg_psel_b = to_b;
        reg_penable = 1'b0;
        reg_pwrite = wr;
        reg_paddr  = a;
        reg_pwdata = d;
        @(negedge clk);
        reg_penable = 1'b1;
        #1 rd = to_b ? prdata_b : prdata_a;
        @(negedge clk);
        reg_psel = 0; reg_psel_b = 0; reg_penable = 0; reg_pwrite = 0;
    endtask

    // Bridge transfer to peripheral idx; samples select in both phases.
    task automatic brg_xfer(input int idx, output logic [NP-1:0] sel_setup,
                            output logic [NP-1:0] sel_acc, output logic [31:0] rd,
                            output logic err, output logic rdy);
        @(negedge clk);
        brg_psel = NP'(1) << idx;
        brg_penable = 1'b0;
        #1 sel_setup = prph_psel;
        @(negedge clk);
        brg_penable = 1'b1;
        #1;
        sel_acc = prph_psel;
        rd  = brg_prdata;
        err = brg_pslverr;
        rdy = brg_pready;
        @(negedge clk);
        brg_psel = '0;
        brg_penable = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0]   rd;
        logic [NP-1:0] s0, s1;
        logic          er, ry;
        int            c;

        do_reset();

        // R1: reset state at the ports
        chk(1, 32'(ahb_en_a), 32'h0000_00FF);
        chk(1, 32'(apb_en_a), 32'h00FF_FFFF);
        c = pc_a3;
        repeat (4) @(negedge clk);
        chk(1, 32'(pc_a3 - c), 32'd4);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            reg_xfer(1'b0, VEC[i][72], VEC[i][71:64], VEC[i][63:32], rd);
            if (!VEC[i][72]) chk(int'(VEC[i][80:73]), rd, VEC[i][31:0]);
        end

        // R11/R2: gate off bit 3, no pulses; back on, full pulses
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFF7, rd);
        chk(2, 32'(apb_en_a), 32'h00FF_FFF7);
        c = pc_a3;
        repeat (4) @(negedge clk);
        chk(11, 32'(pc_a3 - c), 32'd0);
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFFF, rd);
        c = pc_a3;
        repeat (4) @(negedge clk);
        chk(11, 32'(pc_a3 - c), 32'd4);
        #1 chk(11, 32'(apb_gclk_a), 32'h0);          // R11 low phase: all low
        @(posedge clk);
        #1 chk(11, 32'(apb_gclk_a), 32'h00FF_FFFF);  // R11 high phase: all high

        // R6: access to masked peripheral 5
        prph_prdata = 32'hDEAD_BEEF;
        prph_pready = 1'b1;
        prph_pslverr = 1'b0;
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFDF, rd);
        brg_xfer(5, s0, s1, rd, er, ry);
        chk(6, 32'(s0), 32'h0);
        chk(6, 32'(s1), 32'h0);
        chk(6, rd, 32'h0);
        chk(6, 32'(er), 32'd1);
        chk(6, 32'(ry), 32'd1);

        // R7: enabled peripheral 6 passes through, including wait and error
        brg_xfer(6, s0, s1, rd, er, ry);
        chk(7, 32'(s1), 32'h0000_0040);
        chk(7, rd, 32'hDEAD_BEEF);
        chk(7, 32'(er), 32'd0);
        prph_pready = 1'b0;
        prph_pslverr = 1'b1;
        brg_xfer(6, s0, s1, rd, er, ry);
        chk(7, 32'(ry), 32'd0);
        chk(7, 32'(er), 32'd1);
        prph_pready = 1'b1;
        prph_pslverr = 1'b0;

        // R8: re-enable peripheral 5
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFFF, rd);
        brg_xfer(5, s0, s1, rd, er, ry);
        chk(8, 32'(s1), 32'h0000_0020);
        chk(8, rd, 32'hDEAD_BEEF);
        chk(8, 32'(er), 32'd0);

        // R9: clear own bit, then writes are frozen
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFFD, rd);
        reg_xfer(1'b0, 1'b0, 8'h04, 32'h0, rd);
        chk(9, rd, 32'h00FF_FFFD);
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h00FF_FFFF, rd);
        reg_xfer(1'b0, 1'b0, 8'h04, 32'h0, rd);
        chk(9, rd, 32'h00FF_FFFD);
        reg_xfer(1'b0, 1'b1, 8'h00, 32'h0, rd);
        reg_xfer(1'b0, 1'b0, 8'h00, 32'h0, rd);
        chk(9, rd, 32'h0000_00FF);

        // R10: reset restores defaults and unfreezes
        do_reset();
        reg_xfer(1'b0, 1'b0, 8'h04, 32'h0, rd);
        chk(10, rd, 32'h00FF_FFFF);
        reg_xfer(1'b0, 1'b1, 8'h00, 32'h0000_000F, rd);
        reg_xfer(1'b0, 1'b0, 8'h00, 32'h0, rd);
        chk(10, rd, 32'h0000_000F);

        // R9: clearing the bridge bit also freezes
        reg_xfer(1'b0, 1'b1, 8'h00, 32'h0000_00FE, rd);
        reg_xfer(1'b0, 1'b1, 8'h04, 32'h0, rd);
        reg_xfer(1'b0, 1'b0, 8'h04, 32'h0, rd);
        chk(9, rd, 32'h00FF_FFFF);
        reg_xfer(1'b0, 1'b0, 8'h00, 32'h0, rd);
        chk(9, rd, 32'h0000_00FE);
        do_reset();

        // R4: variant without the optional peripheral
        reg_xfer(1'b1, 1'b0, 8'h04, 32'h0, rd);
        chk(4, rd, 32'h00FB_FFFF);
        reg_xfer(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, rd);
        reg_xfer(1'b1, 1'b0, 8'h04, 32'h0, rd);
        chk(4, rd, 32'h00FB_FFFF);
        c = pc_b18;
        s0 = NP'(pc_b17);
        repeat (4) @(negedge clk);
        chk(4, 32'(pc_b18 - c), 32'd0);
        chk(4, 32'(pc_b17) - 32'(s0), 32'd4);

        finish_run();
    end

endmodule